// File: doc/BRIEF.md
# Fixed-Depth Carry-Rewrite Adder

This block adds two unsigned n-bit operands using only bitwise XOR, bitwise AND and a one-place left shift, with no carry ripple or lookahead network. A first stage splits the operands into a partial sum (bits where exactly one operand is set) and a partial carry (bits where both are set). Each later rewrite stage moves the carry one place up and recombines it with the partial sum, so that a carry chain of length k is fully absorbed after k rewrites.

The rewrite stages are unrolled in combinational logic, so the path from operands to result has the same depth for every input pattern. The number of rewrites is a parameter. It defaults to the operand width, which is enough for the exact result. A carry that leaves the top bit is caught from the most significant bit of each carry vector before that vector is shifted, and the carry out is the OR of these bits. A smaller stage count gives a shallower circuit whose result is the partial sum after that many rewrites. That result is not a full add.

The block is purely combinational and sits between registers of the surrounding design. It has no clock and no reset.

Top module: `cdr_adder`

## Requirements
- R1: The first stage forms the partial sum as `a_i XOR b_i` and the partial carry as `a_i AND b_i`. When no bit position has both operands set, `sum_o` equals `a_i XOR b_i` and `carry_o` is 0.
- R2: Each rewrite stage shifts the previous carry vector left by one place, filling a 0 at bit 0. The new partial sum is the previous partial sum XOR that shifted vector. The new carry vector is the previous partial sum AND that shifted vector.
- R3: `carry_o` is the OR of bit WIDTH-1 of every carry vector, each taken before it is shifted. This covers the first-stage vector and the vector of every rewrite stage.
- R4: `sum_o` is the partial sum produced by the last rewrite stage. Example with WIDTH=8 and STAGES=2: inputs 0xFF and 0x01 give `sum_o`=0xF8, and inputs 0x0F and 0x01 give `sum_o`=0x08.
- R5: With STAGES at least WIDTH, `sum_o` equals `(a_i + b_i) mod 2^WIDTH`.
- R6: With STAGES at least WIDTH, `carry_o` equals bit WIDTH of the (WIDTH+1)-bit sum `a_i + b_i`.
- R7: With STAGES at least WIDTH, the last carry vector is all zeros. The longest chain, all ones plus one, therefore produces the exact result.
- R8: The outputs depend on the current inputs only, through a fixed number of stages. For every input pattern the result is valid within the same clock cycle in which the inputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First unsigned operand |
| b_i | input | WIDTH | Second unsigned operand |
| sum_o | output | WIDTH | Partial sum after the last rewrite stage |
| carry_o | output | 1 | OR of the pre-shift top bits of all carry vectors |

## Verification
The assertions assume that both operands carry known 0/1 values. Each check is skipped while any operand bit is unknown, and the bench drives every operand bit from the first cycle onward. The invariants on the stage vectors hold for any stage count. The exact-sum checks and the check on the empty final carry vector are enabled only when the stage count reaches the width. The bench changes operands on one clock edge and reads the results at the opposite edge, so the combinational path settles before every sample.

// File: rtl/cdr_pkg.sv
package cdr_pkg;
  localparam int CDR_WIDTH_DEF = 32;

  // Rewrites needed so that any carry chain drains out of a width-bit word.
  function automatic int cdr_full_stages(input int width);
    return width;
  endfunction
endpackage

// File: rtl/cdr_seed.sv
module cdr_seed #(
  parameter int WIDTH = cdr_pkg::CDR_WIDTH_DEF
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] psum_o,
  output logic [WIDTH-1:0] pand_o
);
  // Split operands into bits set once (sum) and bits set twice (carry).
  always_comb begin
    psum_o = a_i ^ b_i;
    pand_o = a_i & b_i;
  end
endmodule

// File: rtl/cdr_rewrite.sv
module cdr_rewrite #(
  parameter int WIDTH = cdr_pkg::CDR_WIDTH_DEF
) (
  input  logic [WIDTH-1:0] psum_i,
  input  logic [WIDTH-1:0] pand_i,
  output logic [WIDTH-1:0] psum_o,
  output logic [WIDTH-1:0] pand_o
);
  logic [WIDTH-1:0] moved_w;

  // The carry vector's top bit is dropped here; the top level collects it.
  always_comb begin
    moved_w = pand_i << 1;
    psum_o  = psum_i ^ moved_w;
    pand_o  = psum_i & moved_w;
  end
endmodule

// File: rtl/cdr_carry_collect.sv
module cdr_carry_collect #(
  parameter int COUNT = 2
) (
  input  logic [COUNT-1:0] top_bits_i,
  output logic             any_o
);
  always_comb begin
    any_o = |top_bits_i;
  end
endmodule

// File: rtl/cdr_adder.sv
module cdr_adder #(
  parameter int WIDTH  = cdr_pkg::CDR_WIDTH_DEF,
  parameter int STAGES = WIDTH
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o
);
  localparam int NVEC = STAGES + 1;

  logic [NVEC-1:0][WIDTH-1:0] psum_w;
  logic [NVEC-1:0][WIDTH-1:0] pand_w;
  logic [NVEC-1:0]            top_bits_w;

  cdr_seed #(.WIDTH(WIDTH)) u_seed (
    .a_i    (a_i),
    .b_i    (b_i),
    .psum_o (psum_w[0]),
    .pand_o (pand_w[0])
  );

  for (genvar gi = 1; gi < NVEC; gi++) begin : g_stage
    cdr_rewrite #(.WIDTH(WIDTH)) u_stage (
      .psum_i (psum_w[gi-1]),
      .pand_i (pand_w[gi-1]),
      .psum_o (psum_w[gi]),
      .pand_o (pand_w[gi])
    );
  end

  // Top bit of each carry vector, taken before any shift removes it.
  for (genvar gi = 0; gi < NVEC; gi++) begin : g_top
    assign top_bits_w[gi] = pand_w[gi][WIDTH-1];
  end

  cdr_carry_collect #(.COUNT(NVEC)) u_collect (
    .top_bits_i (top_bits_w),
    .any_o      (carry_o)
  );

  assign sum_o = psum_w[STAGES];
endmodule

// File: rtl/cdr_adder_chk.sv
module cdr_adder_chk #(
  parameter int WIDTH  = cdr_pkg::CDR_WIDTH_DEF,
  parameter int STAGES = WIDTH
) (
  input logic [WIDTH-1:0]             a_i,
  input logic [WIDTH-1:0]             b_i,
  input logic [WIDTH-1:0]             sum_o,
  input logic                         carry_o,
  input logic [STAGES:0][WIDTH-1:0]   psum_w,
  input logic [STAGES:0][WIDTH-1:0]   pand_w,
  input logic [STAGES:0]              top_bits_w
);
  localparam bit FULL = STAGES >= cdr_pkg::cdr_full_stages(WIDTH);

  logic known_w;
  assign known_w = !$isunknown({a_i, b_i});

  // R1: the seed split is disjoint and covers every set operand bit.
  always_comb begin
    if (known_w) begin
      p_seed_split_r1: assert (((psum_w[0] & pand_w[0]) == '0) &&
                               ((psum_w[0] | pand_w[0]) == (a_i | b_i)))
        else $error("seed split broken");
    end
  end

  // R2: each rewrite keeps sum and carry disjoint and covers its inputs.
  for (genvar gi = 1; gi <= STAGES; gi++) begin : g_rw
    always_comb begin
      if (known_w) begin
        p_rewrite_cover_r2: assert (((psum_w[gi] & pand_w[gi]) == '0) &&
          ((psum_w[gi] | pand_w[gi]) == (psum_w[gi-1] | (pand_w[gi-1] << 1))))
          else $error("rewrite stage %0d broken", gi);
      end
    end
  end

  // R3: at most one carry can leave the word, so the collected bits are one-hot or empty.
  always_comb begin
    if (known_w) begin
      p_carry_unique_r3: assert ($onehot0(top_bits_w) && (carry_o == (top_bits_w != '0)))
        else $error("carry out collection broken");
    end
  end

  if (FULL) begin : g_full
    // R5, R6: exact add when enough rewrites are present.
    always_comb begin
      if (known_w) begin
        p_exact_sum_r5: assert ({carry_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i}))
          else $error("sum mismatch");
      end
    end
    // R7: the final carry vector has drained.
    always_comb begin
      if (known_w) begin
        p_carry_drained_r7: assert (pand_w[STAGES] == '0)
          else $error("final carry vector not empty");
      end
    end
  end
endmodule

bind cdr_adder cdr_adder_chk #(.WIDTH(WIDTH), .STAGES(STAGES)) u_chk (
  .a_i        (a_i),
  .b_i        (b_i),
  .sum_o      (sum_o),
  .carry_o    (carry_o),
  .psum_w     (psum_w),
  .pand_w     (pand_w),
  .top_bits_w (top_bits_w)
);

// File: tb/cdr_adder_tb.sv
`timescale 1ns/1ps
module cdr_adder_tb;
  logic clk;
  logic rst_n;
  int   n_chk;
  int   n_fail;
  int   cycles;

  logic [31:0] a32, b32, s32;
  logic        c32;
  logic [5:0]  a6, b6, s6;
  logic        c6;
  logic [7:0]  a8, b8, s8;
  logic        c8;

  cdr_adder #(.WIDTH(32)) u_dut (.a_i(a32), .b_i(b32), .sum_o(s32), .carry_o(c32));
  cdr_adder #(.WIDTH(6))  u_dut6 (.a_i(a6), .b_i(b6), .sum_o(s6), .carry_o(c6));
  cdr_adder #(.WIDTH(8), .STAGES(2)) u_dut_short (.a_i(a8), .b_i(b8), .sum_o(s8), .carry_o(c8));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [31:0] a, input logic [31:0] b);
    @(posedge clk);
    a32 = a; b32 = b;
    @(negedge clk);
  endtask

  task automatic t_idle();
    drive(32'h0, 32'h0);
    chk("R4 idle sum", 64'(s32), 64'h0);
    chk("R6 idle carry", 64'(c32), 64'h0);
  endtask

  task automatic t_seed_r1();
    drive(32'h0F0F_3C3C, 32'hF0F0_C3C3);
    chk("R1 disjoint sum", 64'(s32), 64'hFFFF_FFFF);
    chk("R1 disjoint carry", 64'(c32), 64'h0);
    drive(32'h1234_0000, 32'h0000_5678);
    chk("R1 disjoint sum b", 64'(s32), 64'h1234_5678);
  endtask

  task automatic t_chain_r7();
    drive(32'hFFFF_FFFF, 32'h0000_0001);
    chk("R7 longest chain", {31'h0, c32, s32}, 64'h1_0000_0000);
    drive(32'h7FFF_FFFF, 32'h0000_0001);
    chk("R7 chain to msb", {31'h0, c32, s32}, 64'h0_8000_0000);
  endtask

  task automatic t_carry_r3();
    drive(32'h8000_0000, 32'h8000_0000);
    chk("R3 seed msb carry", {31'h0, c32, s32}, 64'h1_0000_0000);
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    chk("R3 all ones", {31'h0, c32, s32}, 64'h1_FFFF_FFFE);
  endtask

  task automatic t_short_r2_r4();
    @(posedge clk); a8 = 8'hFF; b8 = 8'h01; @(negedge clk);
    chk("R4 short FF+01 sum", 64'(s8), 64'hF8);
    chk("R2 short FF+01 carry", 64'(c8), 64'h0);
    @(posedge clk); a8 = 8'h0F; b8 = 8'h01; @(negedge clk);
    chk("R2 short 0F+01 sum", 64'(s8), 64'h08);
    @(posedge clk); a8 = 8'h80; b8 = 8'h80; @(negedge clk);
    chk("R3 short msb carry", {55'h0, c8, s8}, 64'h100);
    @(posedge clk); a8 = 8'h21; b8 = 8'h12; @(negedge clk);
    chk("R1 short no overlap", {55'h0, c8, s8}, 64'h033);
  endtask

  task automatic t_exhaustive6_r5();
    for (int i = 0; i < 64; i++) begin
      for (int j = 0; j < 64; j++) begin
        @(posedge clk);
        a6 = 6'(i); b6 = 6'(j);
        @(negedge clk);
        chk("R5 R6 R8 exhaustive 6-bit", {57'h0, c6, s6}, 64'(i + j));
      end
    end
  endtask

  task automatic t_random32_r6();
    for (int k = 0; k < 2000; k++) begin
      logic [31:0] ra, rb;
      logic [32:0] ref_sum;
      ra = $urandom();
      rb = $urandom();
      ref_sum = {1'b0, ra} + {1'b0, rb};
      drive(ra, rb);
      chk("R5 R6 R8 random 32-bit", {31'h0, c32, s32}, 64'(ref_sum));
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog got=%0d exp=<150000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0;
    a32 = '0; b32 = '0; a6 = '0; b6 = '0; a8 = '0; b8 = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_seed_r1();
    t_chain_r7();
    t_carry_r3();
    t_short_r2_r4();
    t_exhaustive6_r5();
    t_random32_r6();
    finish_run();
  end
endmodule